// File: doc/BRIEF.md
# Six-Channel PWM Commutation Mask

This block sits between a six-output PWM generator and the gate-drive pins of a three-phase inverter. Each output pin either follows its generator channel or is held at a fixed level chosen by software. Even channels (0, 2, 4) drive the upper switch of each leg and odd channels (1, 3, 5) drive the lower switch.

Two phase-change words control the override. The live word decides what reaches the pins now. The staged word is prepared ahead of time and is copied whole into the live word when a one-cycle commutation pulse arrives. The new pattern therefore lands on all six pins at one clock edge, with no partial update.

Each word packs a 6-bit override-enable field and a 6-bit override-level field. Both words are written through one register write port and can be read back on a combinational read port. The pins are registered. A change in the live word reaches the pins one clock after the live word itself changes.

The live-word update source is chosen each cycle from three named cases:
- `ACT_HOLD`: no change.
- `ACT_WRITE`: software write to the live word.
- `ACT_COMMUTE`: copy of the staged word.

`ACT_COMMUTE` has top priority. Any cycle with `commute` high selects it. Otherwise a live-word write selects `ACT_WRITE`. Otherwise the case is `ACT_HOLD`.

Top module: `pwm_commute_mask`

## Requirements
- R1: After reset, both words read 16'h0000 and `pin_out` is 6'h00.
- R2: When enable bit n of the live word is 0, `pin_out[n]` equals the `pwm_in[n]` sampled at the same clock edge that updates the pin register.
- R3: When enable bit n of the live word is 1, `pin_out[n]` is held at level bit n of the live word, whatever `pwm_in[n]` does.
- R4: Word layout: bits [13:8] are the enable field and bits [5:0] are the level field, with channel n at offset n in each field. A write with `wr_sel`=0 loads the live word at the next edge. A write with `wr_sel`=1 loads the staged word. `rd_sel`=0 reads the live word and `rd_sel`=1 reads the staged word.
- R5: Bits [15:14] and [7:6] of both words read as zero, and values written to them are discarded.
- R6: A write to the staged word leaves `pin_out` and the live word unchanged until a commutation pulse arrives.
- R7: On a `commute` pulse, the live word becomes the staged word as it stood before that edge, all in one clock. All six pins switch together at the following edge. The staged word keeps its value.
- R8: If `commute` and a live-word write happen in the same cycle, the live word takes the staged word and the write is lost.
- R9: With enable 6'b111110 and level 6'b001000, pin 0 follows `pwm_in[0]`, pin 3 is high, and pins 1, 2, 4 and 5 are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 live word, 1 staged word |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read source: 0 live word, 1 staged word |
| rd_data | output | 16 | Read data, reserved bits zero |
| commute | input | 1 | One-cycle commutation pulse |
| pwm_in | input | 6 | Generator channels 0..5 |
| pin_out | output | 6 | Registered gate-drive pins 0..5 |

## Verification
The bench builds the block with the package defaults: six channels, a 16-bit word, and the enable field at bit 8. This makes every pin, both reserved gaps and the enable/level bit pairing observable through the read port. With all six channels present, the upper/lower leg pattern of the commutation example can be driven directly. The one-edge delay between a word change and the pins is measured. This delay is what separates a pending staged write from a committed one.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
    localparam int NCH     = 6;
    localparam int REG_W   = 16;
    localparam int EN_LSB  = 8;
    localparam int DAT_LSB = 0;

    typedef struct packed {
        logic [NCH-1:0] en;
        logic [NCH-1:0] dat;
    } pcm_word_t;

    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_WRITE   = 2'd1,
        ACT_COMMUTE = 2'd2
    } act_src_e;

    function automatic pcm_word_t unpack_word(input logic [REG_W-1:0] w);
        pcm_word_t p;
        p.en  = w[EN_LSB +: NCH];
        p.dat = w[DAT_LSB +: NCH];
        return p;
    endfunction

    function automatic logic [REG_W-1:0] pack_word(input pcm_word_t p);
        logic [REG_W-1:0] r;
        r = '0;
        r[EN_LSB +: NCH]  = p.en;
        r[DAT_LSB +: NCH] = p.dat;
        return r;
    endfunction
endpackage

// File: rtl/pcm_slot.sv
module pcm_slot
    import pcm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  pcm_word_t d,
    output pcm_word_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/pcm_override.sv
module pcm_override #(
    parameter int NCH = 6
) (
    input  logic [NCH-1:0] en,
    input  logic [NCH-1:0] dat,
    input  logic [NCH-1:0] pwm,
    output logic [NCH-1:0] pins
);
    for (genvar n = 0; n < NCH; n++) begin : g_ch
        assign pins[n] = en[n] ? dat[n] : pwm[n];
    end
endmodule

// File: rtl/pwm_commute_mask.sv
module pwm_commute_mask
    import pcm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    input  logic             commute,
    input  logic [NCH-1:0]   pwm_in,
    output logic [NCH-1:0]   pin_out
);
    localparam logic SEL_ACT = 1'b0;
    localparam logic SEL_NXT = 1'b1;

    pcm_word_t act_q, nxt_q, act_d, wr_word;
    logic      act_load, nxt_load;
    act_src_e  act_src;
    logic [NCH-1:0] pin_d, pin_q;

    assign wr_word  = unpack_word(wr_data);
    assign nxt_load = wr_en && (wr_sel == SEL_NXT);

    // Source selection: commutation outranks a software write.
    always_comb begin
        if (commute) begin
            act_src = ACT_COMMUTE;
        end else if (wr_en && (wr_sel == SEL_ACT)) begin
            act_src = ACT_WRITE;
        end else begin
            act_src = ACT_HOLD;
        end
    end

    always_comb begin
        unique case (act_src)
            ACT_COMMUTE: begin
                act_load = 1'b1;
                act_d    = nxt_q;
            end
            ACT_WRITE: begin
                act_load = 1'b1;
                act_d    = wr_word;
            end
            default: begin
                act_load = 1'b0;
                act_d    = act_q;
            end
        endcase
    end

    pcm_slot u_nxt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (nxt_load),
        .d     (wr_word),
        .q     (nxt_q)
    );

    pcm_slot u_act (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (act_load),
        .d     (act_d),
        .q     (act_q)
    );

    pcm_override #(.NCH(NCH)) u_ovr (
        .en   (act_q.en),
        .dat  (act_q.dat),
        .pwm  (pwm_in),
        .pins (pin_d)
    );

    // Registered pins: all six change on one edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '0;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign pin_out = pin_q;
    assign rd_data = pack_word((rd_sel == SEL_NXT) ? nxt_q : act_q);
endmodule

// File: rtl/pcm_chk.sv
module pcm_chk
    import pcm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             commute,
    input logic [NCH-1:0]   pwm_in,
    input logic [NCH-1:0]   pin_out,
    input pcm_word_t        act_q,
    input pcm_word_t        nxt_q
);
    localparam logic [REG_W-1:0] RESV = ~pack_word('1);

    p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pin_out ^ $past(pwm_in)) & ~$past(act_q.en)) == '0));

    p_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pin_out ^ $past(act_q.dat)) & $past(act_q.en)) == '0));

    p_act_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && !commute) |=> (act_q == unpack_word($past(wr_data))));

    p_resv_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & RESV) == '0);

    p_nxt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel) |=> $stable(nxt_q));

    p_commute_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commute |=> (act_q == $past(nxt_q)));

    p_trig_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commute && wr_en && !wr_sel) |=> (act_q == $past(nxt_q)));
endmodule

bind pwm_commute_mask pcm_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .commute (commute),
    .pwm_in  (pwm_in),
    .pin_out (pin_out),
    .act_q   (act_q),
    .nxt_q   (nxt_q)
);

// File: tb/pwm_commute_mask_tb_top.sv
module pwm_commute_mask_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [15:0] rd_data;
    logic        commute = 1'b0;
    logic [5:0]  pwm_in = '0;
    logic [5:0]  pin_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_commute_mask dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .commute (commute),
        .pwm_in  (pwm_in),
        .pin_out (pin_out)
    );

    // {enable, level, pwm, expected pins}
    localparam logic [23:0] VEC [6] = '{
        {6'h00, 6'h3F, 6'h15, 6'h15},
        {6'h3F, 6'h2A, 6'h15, 6'h2A},
        {6'h0F, 6'h05, 6'h30, 6'h35},
        {6'h30, 6'h10, 6'h0F, 6'h1F},
        {6'h2A, 6'h00, 6'h3F, 6'h15},
        {6'h15, 6'h3F, 6'h00, 6'h15}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_word(input logic sel, output logic [15:0] d);
        rd_sel = sel;
        #0.5;
        d = rd_data;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv;
        repeat (3) @(negedge clk);
        // R1 reset state
        read_word(1'b0, rv); check("R1 live word", rv, 16'h0000);
        read_word(1'b1, rv); check("R1 staged word", rv, 16'h0000);
        check("R1 pins", {10'h0, pin_out}, 16'h0000);
        rst_n = 1'b1;

        // R2/R3/R4 vector table via live-word writes
        foreach (VEC[i]) begin
            pwm_in = VEC[i][11:6];
            reg_write(1'b0, {2'b00, VEC[i][23:18], 2'b00, VEC[i][17:12]});
            @(negedge clk);
            check("R2/R3 vector pins", {10'h0, pin_out}, {10'h0, VEC[i][5:0]});
        end

        // R4/R5 readback layout and reserved bits
        reg_write(1'b0, 16'hFFFF);
        read_word(1'b0, rv); check("R5 live reserved", rv, 16'h3F3F);
        reg_write(1'b1, 16'hC1C2);
        read_word(1'b1, rv); check("R4 staged layout", rv, 16'h0102);
        pwm_in = 6'h00;
        @(negedge clk);
        check("R3 all forced high", {10'h0, pin_out}, 16'h003F);

        // R2 cycle-by-cycle follow
        reg_write(1'b0, 16'h0000);
        for (int k = 0; k < 8; k++) begin
            pwm_in = 6'(k * 9 + 1);
            @(negedge clk);
            check("R2 follow", {10'h0, pin_out}, {10'h0, 6'(k * 9 + 1)});
        end

        // R6 staged write has no effect
        pwm_in = 6'h2A;
        reg_write(1'b1, 16'h3F00);
        repeat (3) @(negedge clk);
        check("R6 pins unchanged", {10'h0, pin_out}, 16'h002A);
        read_word(1'b0, rv); check("R6 live unchanged", rv, 16'h0000);

        // R7 commutation
        commute = 1'b1;
        @(negedge clk);
        commute = 1'b0;
        check("R7 pins one edge later", {10'h0, pin_out}, 16'h002A);
        read_word(1'b0, rv); check("R7 live copied", rv, 16'h3F00);
        @(negedge clk);
        check("R7 pins switched", {10'h0, pin_out}, 16'h0000);
        read_word(1'b1, rv); check("R7 staged kept", rv, 16'h3F00);

        // R8 trigger beats live write; R9 example pattern
        reg_write(1'b1, 16'h3E08);
        @(negedge clk);
        commute = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h0000;
        @(negedge clk);
        commute = 1'b0; wr_en = 1'b0;
        read_word(1'b0, rv); check("R8 trigger wins", rv, 16'h3E08);
        pwm_in = 6'h3F;
        @(negedge clk);
        check("R9 pwm high", {10'h0, pin_out}, 16'h0009);
        pwm_in = 6'h00;
        @(negedge clk);
        check("R9 pwm low", {10'h0, pin_out}, 16'h0008);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule